// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Once it is enabled and its run bit is set, it holds the analog front end in sampling for a fixed number of clocks. It then searches for the input level one bit at a time, from the top bit downwards. For each bit it presents a trial code to an external resistor-ladder DAC, waits a fixed settling time and reads one comparator bit. That bit decides whether the trial bit stays set.

When the last bit has been decided, the code is stored left-justified in a 16-bit result word and a one-cycle end-of-conversion interrupt fires. The result is read whole or one byte at a time. A 3-bit channel register steers an external eight-way input multiplexer. Writing that register, or writing the run bit again, during a conversion abandons the conversion and restarts it from sampling. While run stays set, conversions follow one another with no gap.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the result word is 0x0000, `eoc_irq` is low, `sample_hold` is low and `trial_code` is zero.
- R2: A conversion starts only while both `ctl_en` and `ctl_run` are high. With `ctl_en` low, nothing is sampled, no interrupt fires and the result does not change.
- R3: A conversion opens with `SAMPLE_CYC` clocks of `sample_hold` high. The first trial code after that is 0x200: the top bit set and all lower bits zero.
- R4: Each bit trial presents `trial_code` for `SETTLE_CYC` clocks. `cmp_hi`=1 (input at or above the tap) keeps the trial bit and `cmp_hi`=0 clears it. The bit below is then set for the next trial. For an ideal input code v, the result is v.
- R5: `eoc_irq` rises `SAMPLE_CYC + 10*SETTLE_CYC` clock edges after the first edge that sees a start, and the new result is readable in that same cycle.
- R6: The result word holds the 10-bit code in bits 15:6, and bits 5:0 read as zero.
- R7: `rd_word` returns the whole word. `rd_byte` returns bits 15:8 when `rd_addr`=1 and bits 7:0 when `rd_addr`=0.
- R8: The result word changes only in the cycle in which `eoc_irq` is high.
- R9: `eoc_irq` is a single-cycle pulse, one per completed conversion.
- R10: While `ctl_run` stays high, conversions repeat with a period of `SAMPLE_CYC + 10*SETTLE_CYC` clocks.
- R11: A `ch_wr` pulse loads `ch_wdata` into the channel register, which drives `ana_sel` from the next cycle.
- R12: A `ch_wr` or `ctl_run_wr` pulse during a conversion abandons it without a result update or an interrupt, and a full conversion restarts from sampling.
- R13: Dropping `ctl_run` or `ctl_en` during a conversion stops it without a result update or an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_en | input | 1 | Converter enable |
| ctl_run | input | 1 | Run bit, level |
| ctl_run_wr | input | 1 | Pulse: software wrote the run bit as 1 |
| ch_wr | input | 1 | Pulse: channel register write |
| ch_wdata | input | 3 | Channel to write |
| ana_sel | output | 3 | Channel driven to the input multiplexer |
| sample_hold | output | 1 | High while the front end samples |
| trial_code | output | 10 | Code to the ladder DAC |
| cmp_hi | input | 1 | Comparator: input at or above the tap |
| eoc_irq | output | 1 | End-of-conversion pulse |
| rd_addr | input | 1 | Byte select: 1 high byte, 0 low byte |
| rd_byte | output | 8 | Selected result byte |
| rd_word | output | 16 | Whole result word |

## Verification
The bench builds the block with `SAMPLE_CYC`=3 and `SETTLE_CYC`=2, so each conversion lasts 23 clocks. That is short enough to run every one of the 1024 input codes through an ideal comparator model, rotating across all eight channels and giving the other channels different levels. At that length the abort, stop and back-to-back cases can be timed to the exact clock, and the latency and period of each can be compared with the arithmetic expected from the requirements.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  localparam int unsigned SARC_BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_TRIAL  = 2'd2
  } sarc_state_e;

  // clocks from the first start edge to the end of a conversion
  function automatic int unsigned sarc_conv_cycles(input int unsigned samp,
                                                   input int unsigned settle,
                                                   input int unsigned nbits);
    return samp + nbits * settle;
  endfunction
endpackage

// File: rtl/sarc_timer.sv
module sarc_timer #(
  parameter int unsigned SAMPLE_CYC = 4,
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic in_sample,
  output logic last
);
  localparam int unsigned MAXC  = (SAMPLE_CYC > SETTLE_CYC) ? SAMPLE_CYC : SETTLE_CYC;
  localparam int unsigned CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;

  assign last = in_sample ? (cnt == CNT_W'(SAMPLE_CYC - 1))
                          : (cnt == CNT_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr | last) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sarc_sar.sv
module sarc_sar #(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned PTR_W    = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                first,
  input  logic                decide,
  input  logic                cmp,
  output logic [RES_BITS-1:0] code,
  output logic [PTR_W-1:0]    bitp,
  output logic                last_bit,
  output logic [RES_BITS-1:0] decided
);
  localparam logic [PTR_W-1:0] MSB = PTR_W'(RES_BITS - 1);

  function automatic logic [RES_BITS-1:0] put_bit(input logic [RES_BITS-1:0] c,
                                                  input logic [PTR_W-1:0]    p,
                                                  input logic                b);
    logic [RES_BITS-1:0] r;
    r    = c;
    r[p] = b;
    return r;
  endfunction

  assign decided  = put_bit(code, bitp, cmp);
  assign last_bit = (bitp == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      bitp <= MSB;
    end else if (clr) begin
      code <= '0;
      bitp <= MSB;
    end else if (first) begin
      code <= put_bit('0, MSB, 1'b1);
      bitp <= MSB;
    end else if (decide && !last_bit) begin
      code <= put_bit(decided, bitp - 1'b1, 1'b1);
      bitp <= bitp - 1'b1;
    end
  end
endmodule

// File: rtl/sarc_result.sv
module sarc_result #(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned REG_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RES_BITS-1:0] din,
  input  logic                rd_addr,
  output logic [7:0]          rd_byte,
  output logic [REG_W-1:0]    rd_word
);
  localparam int unsigned PAD_W = REG_W - RES_BITS;

  logic [RES_BITS-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (load) res_q <= din;
  end

  assign rd_word = {res_q, {PAD_W{1'b0}}};
  assign rd_byte = rd_addr ? rd_word[REG_W-1 -: sarc_pkg::SARC_BYTE_W]
                           : rd_word[sarc_pkg::SARC_BYTE_W-1:0];
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned RES_BITS   = 10,
  parameter int unsigned REG_W      = 16,
  parameter int unsigned CH_W       = 3,
  parameter int unsigned SAMPLE_CYC = 4,
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_en,
  input  logic                ctl_run,
  input  logic                ctl_run_wr,
  input  logic                ch_wr,
  input  logic [CH_W-1:0]     ch_wdata,
  output logic [CH_W-1:0]     ana_sel,
  output logic                sample_hold,
  output logic [RES_BITS-1:0] trial_code,
  input  logic                cmp_hi,
  output logic                eoc_irq,
  input  logic                rd_addr,
  output logic [7:0]          rd_byte,
  output logic [REG_W-1:0]    rd_word
);
  import sarc_pkg::*;
  localparam int unsigned PTR_W = $clog2(RES_BITS);

  sarc_state_e         state, state_nx;
  logic                go, busy, abort, tm_last, trial_active;
  logic                enter_trial, decide, done, last_bit;
  logic [PTR_W-1:0]    bitp;
  logic [RES_BITS-1:0] decided;
  logic [CH_W-1:0]     ch_q;

  assign go           = ctl_en & ctl_run;
  assign busy         = (state != ST_IDLE);
  assign abort        = busy & (~go | ch_wr | ctl_run_wr);
  assign sample_hold  = (state == ST_SAMPLE);
  assign trial_active = (state == ST_TRIAL);
  assign enter_trial  = sample_hold & tm_last & ~abort;
  assign decide       = trial_active & tm_last & ~abort;
  assign done         = decide & last_bit;
  assign ana_sel      = ch_q;

  always_comb begin
    state_nx = state;
    if (abort) state_nx = go ? ST_SAMPLE : ST_IDLE;
    else begin
      case (state)
        ST_IDLE:   if (go)          state_nx = ST_SAMPLE;
        ST_SAMPLE: if (enter_trial) state_nx = ST_TRIAL;
        ST_TRIAL:  if (done)        state_nx = ST_SAMPLE;
        default:                    state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      eoc_irq <= 1'b0;
      ch_q    <= '0;
    end else begin
      state   <= state_nx;
      eoc_irq <= done;
      if (ch_wr) ch_q <= ch_wdata;
    end
  end

  sarc_timer #(.SAMPLE_CYC(SAMPLE_CYC), .SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clr(~busy | abort),
    .in_sample(sample_hold),
    .last(tm_last)
  );

  sarc_sar #(.RES_BITS(RES_BITS), .PTR_W(PTR_W)) u_sar (
    .clk(clk), .rst_n(rst_n),
    .clr(~busy | abort | done),
    .first(enter_trial),
    .decide(decide),
    .cmp(cmp_hi),
    .code(trial_code),
    .bitp(bitp),
    .last_bit(last_bit),
    .decided(decided)
  );

  sarc_result #(.RES_BITS(RES_BITS), .REG_W(REG_W)) u_result (
    .clk(clk), .rst_n(rst_n),
    .load(done),
    .din(decided),
    .rd_addr(rd_addr),
    .rd_byte(rd_byte),
    .rd_word(rd_word)
  );
endmodule

// File: rtl/sarc_checker.sv
module sarc_checker #(
  parameter int unsigned RES_BITS = 10,
  parameter int unsigned REG_W    = 16,
  parameter int unsigned PTR_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctl_en,
  input logic                sample_hold,
  input logic                busy,
  input logic                trial_active,
  input logic [RES_BITS-1:0] trial_code,
  input logic [PTR_W-1:0]    bitp,
  input logic                eoc_irq,
  input logic [REG_W-1:0]    rd_word
);
  logic [RES_BITS-1:0] low_mask;
  assign low_mask = (RES_BITS'(1) << bitp) - 1'b1;

  AST_RESULT_ONLY_AT_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_word) |-> eoc_irq);                                       // R8
  AST_EOC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |=> !eoc_irq);                                                // R9
  AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sample_hold) && busy) |-> (trial_code == {1'b1, {(RES_BITS-1){1'b0}}})); // R3
  AST_TRIAL_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    trial_active |-> ((trial_code & low_mask) == '0));                    // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> !busy);                                                   // R2
  AST_EOC_FROM_TRIAL: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> $past(trial_active));                                     // R5
endmodule

bind sar_adc_ctrl sarc_checker #(.RES_BITS(RES_BITS), .REG_W(REG_W), .PTR_W(PTR_W)) u_sarc_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .sample_hold(sample_hold),
  .busy(busy), .trial_active(trial_active), .trial_code(trial_code),
  .bitp(bitp), .eoc_irq(eoc_irq), .rd_word(rd_word)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
  localparam int RES  = 10;
  localparam int S    = 3;
  localparam int T    = 2;
  localparam int CONV = S + RES * T;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ctl_en, ctl_run, ctl_run_wr, ch_wr, cmp_hi, eoc_irq, rd_addr, sample_hold;
  logic [2:0]  ch_wdata, ana_sel;
  logic [9:0]  trial_code;
  logic [7:0]  rd_byte;
  logic [15:0] rd_word;
  logic [9:0]  vin [8];

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  assign cmp_hi = (vin[ana_sel] >= trial_code);

  sar_adc_ctrl #(.RES_BITS(RES), .REG_W(16), .CH_W(3), .SAMPLE_CYC(S), .SETTLE_CYC(T)) i_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_run(ctl_run), .ctl_run_wr(ctl_run_wr),
    .ch_wr(ch_wr), .ch_wdata(ch_wdata), .ana_sel(ana_sel), .sample_hold(sample_hold),
    .trial_code(trial_code), .cmp_hi(cmp_hi), .eoc_irq(eoc_irq), .rd_addr(rd_addr),
    .rd_byte(rd_byte), .rd_word(rd_word)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic load_levels(input int ch, input int v);
    for (int i = 0; i < 8; i++) vin[i] = 10'(~v ^ i);
    vin[ch] = 10'(v);
  endtask

  task automatic write_ch(input int ch);
    @(negedge clk); ch_wr = 1'b1; ch_wdata = 3'(ch);
    @(negedge clk); ch_wr = 1'b0;
  endtask

  // full conversion of level v on channel ch; the result is checked arithmetically
  task automatic convert(input int ch, input int v);
    int cnt;
    bit moved;
    logic [15:0] prev;
    load_levels(ch, v);
    write_ch(ch);
    check("R11 channel", 32'(ana_sel), 32'(ch));
    prev = rd_word; moved = 0; cnt = 0;
    ctl_run = 1'b1;
    do begin
      @(negedge clk); cnt++;
      if (cnt == 1)     check("R3 sampling", 32'(sample_hold), 1);
      if (cnt == S + 1) check("R3 first trial", 32'(trial_code), 32'h200);
      if (!eoc_irq && rd_word !== prev) moved = 1;
    end while (!eoc_irq && cnt < 4 * CONV);
    check("R5 latency", 32'(cnt), 32'(CONV + 1));
    check("R8 result held", 32'(moved), 0);
    check("R4 R6 word", 32'(rd_word), 32'(v * 64));
    rd_addr = 1'b1; #1;
    check("R7 high byte", 32'(rd_byte), 32'(v / 4));
    rd_addr = 1'b0; #1;
    check("R7 low byte", 32'(rd_byte), 32'((v % 4) * 64));
    ctl_run = 1'b0;
    @(negedge clk);
    check("R9 pulse", 32'(eoc_irq), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    bit seen;
    bit moved;
    logic [15:0] prev;
    rst_n = 1'b0; ctl_en = 1'b0; ctl_run = 1'b0; ctl_run_wr = 1'b0;
    ch_wr = 1'b0; ch_wdata = '0; rd_addr = 1'b0;
    for (int i = 0; i < 8; i++) vin[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 word", 32'(rd_word), 0);
    check("R1 eoc", 32'(eoc_irq), 0);
    check("R1 sample", 32'(sample_hold), 0);
    check("R1 trial", 32'(trial_code), 0);

    // R2: run without enable does nothing
    load_levels(0, 777);
    ctl_run = 1'b1; seen = 0;
    repeat (3 * CONV) begin @(negedge clk); if (eoc_irq || sample_hold) seen = 1; end
    check("R2 disabled activity", 32'(seen), 0);
    check("R2 disabled result", 32'(rd_word), 0);
    ctl_run = 1'b0;
    ctl_en = 1'b1;

    // R4/R5/R6/R7: every code, rotating channels
    for (int v = 0; v < 1024; v++) convert(v % 8, v);

    // R10: back-to-back conversions
    load_levels(5, 683);
    write_ch(5);
    ctl_run = 1'b1;
    do @(negedge clk); while (!eoc_irq);
    for (int k = 0; k < 3; k++) begin
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!eoc_irq && cnt < 4 * CONV);
      check("R10 period", 32'(cnt), 32'(CONV));
      check("R10 result", 32'(rd_word), 32'(683 * 64));
    end
    ctl_run = 1'b0;
    @(negedge clk);

    // R12: channel write mid-conversion
    convert(1, 100);
    vin[1] = 10'd100; vin[2] = 10'd900;
    ctl_run = 1'b1;
    repeat (9) @(negedge clk);
    prev = rd_word;
    ch_wr = 1'b1; ch_wdata = 3'd2; cnt = 0; moved = 0;
    do begin
      @(negedge clk); ch_wr = 1'b0; cnt++;
      if (!eoc_irq && rd_word !== prev) moved = 1;
    end while (!eoc_irq && cnt < 4 * CONV);
    check("R12 channel abort latency", 32'(cnt), 32'(CONV + 1));
    check("R12 channel abort no update", 32'(moved), 0);
    check("R12 channel abort result", 32'(rd_word), 32'(900 * 64));
    ctl_run = 1'b0;
    @(negedge clk);

    // R12: repeated start mid-conversion
    load_levels(3, 321);
    write_ch(3);
    ctl_run = 1'b1;
    repeat (14) @(negedge clk);
    prev = rd_word;
    ctl_run_wr = 1'b1; cnt = 0; moved = 0;
    do begin
      @(negedge clk); ctl_run_wr = 1'b0; cnt++;
      if (!eoc_irq && rd_word !== prev) moved = 1;
    end while (!eoc_irq && cnt < 4 * CONV);
    check("R12 restart latency", 32'(cnt), 32'(CONV + 1));
    check("R12 restart no update", 32'(moved), 0);
    check("R12 restart result", 32'(rd_word), 32'(321 * 64));
    ctl_run = 1'b0;
    @(negedge clk);

    // R13: run dropped, then enable dropped, mid-conversion
    load_levels(4, 55);
    write_ch(4);
    prev = rd_word;
    ctl_run = 1'b1;
    repeat (10) @(negedge clk);
    ctl_run = 1'b0; seen = 0;
    repeat (2 * CONV) begin @(negedge clk); if (eoc_irq) seen = 1; end
    check("R13 run drop no eoc", 32'(seen), 0);
    check("R13 run drop result", 32'(rd_word), 32'(prev));
    check("R13 run drop idle", 32'(sample_hold), 0);
    ctl_run = 1'b1;
    repeat (12) @(negedge clk);
    ctl_en = 1'b0; seen = 0;
    repeat (2 * CONV) begin @(negedge clk); if (eoc_irq || sample_hold) seen = 1; end
    check("R13 enable drop quiet", 32'(seen), 0);
    check("R13 enable drop result", 32'(rd_word), 32'(prev));
    ctl_run = 1'b0;

    finish_run();
  end
endmodule